// File: doc/BRIEF.md
# Programmable Two-Digit Combination Lock

This block is a Moore-style state machine that guards a door. A user sets a code word on switches and pulses Enter to submit it as one digit; two digits in a row make one attempt. When both digits match the stored combination the lock releases and drives `open_o` high. A wrong attempt is reported only after the second digit has been submitted, so an observer learns nothing about which digit was at fault. The code word width and the factory combination are parameters.

While the lock stands open, a further Enter starts programming. The next two submitted digits are the new combination. The first of them is staged and both are written together when the second arrives, at which point the lock returns to the open state. A ResetCombo pulse restores the factory combination and re-arms the lock. The synchronous reset re-arms the lock as well, but it keeps the stored combination. A 3-bit status word drives an external character display.

Top module: `combo_lock`

## Requirements
- R1: While `rst` is high and after it falls, `status_o` is 0 (idle) and `open_o` is 0. `rst` does not change `combo_o`.
- R2: A `reset_combo_i` pulse loads `combo_o` with the factory combination in every state. With the defaults this is first digit 2'b11 in bits [3:2] and second digit 2'b01 in bits [1:0]. The same pulse returns `status_o` to 0 one cycle later.
- R3: While `enter_i` is low, `status_o`, `open_o` and `combo_o` hold their values whatever `code_i` does.
- R4: In idle, an Enter with the stored first digit followed by an Enter with the stored second digit gives `status_o` = 2 and `open_o` = 1, starting one cycle after the second Enter.
- R5: In idle, any Enter gives `status_o` = 1 (waiting for the second digit), never 5. If the first digit was wrong, the next Enter gives `status_o` = 5 (error) whatever the second digit is.
- R6: A correct first digit followed by a wrong second digit gives `status_o` = 5 and `open_o` = 0.
- R7: An Enter in the error state returns `status_o` to 0.
- R8: An Enter in the open state gives `status_o` = 3 (programming, first digit) and `open_o` = 0.
- R9: An Enter in the programming-first state stages `code_i` and gives `status_o` = 4. `combo_o` stays unchanged.
- R10: An Enter in the programming-second state writes the staged digit into `combo_o[2*DIGIT_W-1:DIGIT_W]` and `code_i` into `combo_o[DIGIT_W-1:0]`, and returns `status_o` to 2. After that only the new combination opens the lock.
- R11: Priority is `rst` first, then `reset_combo_i`, then `enter_i`. An Enter in the same cycle as `reset_combo_i` is discarded and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; re-arms the lock |
| code_i | input | DIGIT_W | Digit presented on the switches |
| enter_i | input | 1 | One-cycle submit pulse |
| reset_combo_i | input | 1 | One-cycle pulse restoring the factory combination |
| open_o | output | 1 | Lock released |
| combo_o | output | 2*DIGIT_W | Stored combination, first digit in upper half |
| status_o | output | 3 | 0 idle, 1 waiting second digit, 2 open, 3 prog first, 4 prog second, 5 error |

## Verification
The bench builds the block with its defaults: 2-bit digits and factory combination 3 then 1. These leave only sixteen possible attempts, so every one of them is tried and each must end in either open or error. Only the single matching pair may open the lock, and none may report an error after the first digit. The same small space allows a reprogrammed combination to be checked against the old one after a reset that keeps it.

// File: rtl/lock_pkg.sv
package lock_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_W2_OK  = 3'd1,
      ST_W2_BAD = 3'd2,
      ST_OPEN   = 3'd3,
      ST_PROG1  = 3'd4,
      ST_PROG2  = 3'd5,
      ST_ERR    = 3'd6
   } lock_state_t;

   localparam int STATUS_W = 3;

   localparam logic [STATUS_W-1:0] STAT_IDLE  = 3'd0;
   localparam logic [STATUS_W-1:0] STAT_WAIT2 = 3'd1;
   localparam logic [STATUS_W-1:0] STAT_OPEN  = 3'd2;
   localparam logic [STATUS_W-1:0] STAT_PROG1 = 3'd3;
   localparam logic [STATUS_W-1:0] STAT_PROG2 = 3'd4;
   localparam logic [STATUS_W-1:0] STAT_ERROR = 3'd5;

   // Both second-digit states look the same on the display
   function automatic logic [STATUS_W-1:0] status_of(lock_state_t s);
      case (s)
         ST_W2_OK, ST_W2_BAD: status_of = STAT_WAIT2;
         ST_OPEN:             status_of = STAT_OPEN;
         ST_PROG1:            status_of = STAT_PROG1;
         ST_PROG2:            status_of = STAT_PROG2;
         ST_ERR:              status_of = STAT_ERROR;
         default:             status_of = STAT_IDLE;
      endcase
   endfunction

endpackage

// File: rtl/lock_combo_store.sv
module lock_combo_store #(
   parameter int DIGIT_W    = 2,
   parameter int RST_FIRST  = 3,
   parameter int RST_SECOND = 1
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   restore_i,
   input  logic                   stage_i,
   input  logic                   commit_i,
   input  logic [DIGIT_W-1:0]     code_i,
   output logic [2*DIGIT_W-1:0]   combo_o,
   output logic [DIGIT_W-1:0]     first_o,
   output logic [DIGIT_W-1:0]     second_o
);
   localparam int NUM_DIGITS = 2;
   localparam int COMBO_W    = NUM_DIGITS * DIGIT_W;
   localparam logic [COMBO_W-1:0] FACTORY =
      {RST_FIRST[DIGIT_W-1:0], RST_SECOND[DIGIT_W-1:0]};

   logic [DIGIT_W-1:0] pend_q;
   logic [COMBO_W-1:0] new_vec;

   // First programmed digit waits here until the second arrives
   always_ff @(posedge clk) begin
      if (stage_i)
         pend_q <= code_i;
   end

   assign new_vec = {pend_q, code_i};

   generate
      for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_slot
         logic [DIGIT_W-1:0] slot_q;
         always_ff @(posedge clk) begin
            if (restore_i)
               slot_q <= FACTORY[g*DIGIT_W +: DIGIT_W];
            else if (commit_i)
               slot_q <= new_vec[g*DIGIT_W +: DIGIT_W];
         end
         assign combo_o[g*DIGIT_W +: DIGIT_W] = slot_q;
      end
   endgenerate

   assign first_o  = combo_o[COMBO_W-1:DIGIT_W];
   assign second_o = combo_o[DIGIT_W-1:0];

   AST_RESTORE_FACTORY: assert property (@(posedge clk) disable iff (rst)
      restore_i |=> (combo_o == FACTORY)) else $error("factory load missed"); // R2

   AST_COMBO_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!restore_i && !commit_i) |=> $stable(combo_o)) else $error("combo moved"); // R3

endmodule

// File: rtl/lock_fsm.sv
module lock_fsm
   import lock_pkg::*;
#(
   parameter int DIGIT_W = 2
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               restore_i,
   input  logic               enter_i,
   input  logic [DIGIT_W-1:0] code_i,
   input  logic [DIGIT_W-1:0] first_i,
   input  logic [DIGIT_W-1:0] second_i,
   output lock_state_t        state_o,
   output logic               stage_o,
   output logic               commit_o
);
   lock_state_t state_q, state_d;

   always_ff @(posedge clk) begin
      if (rst)
         state_q <= ST_IDLE;
      else
         state_q <= state_d;
   end

   always_comb begin
      state_d = state_q;
      if (restore_i) begin
         state_d = ST_IDLE;
      end else if (enter_i) begin
         case (state_q)
            ST_IDLE:   state_d = (code_i == first_i)  ? ST_W2_OK : ST_W2_BAD;
            ST_W2_OK:  state_d = (code_i == second_i) ? ST_OPEN  : ST_ERR;
            ST_W2_BAD: state_d = ST_ERR;
            ST_OPEN:   state_d = ST_PROG1;
            ST_PROG1:  state_d = ST_PROG2;
            ST_PROG2:  state_d = ST_OPEN;
            ST_ERR:    state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
         endcase
      end
   end

   assign stage_o  = !rst && !restore_i && enter_i && (state_q == ST_PROG1);
   assign commit_o = !rst && !restore_i && enter_i && (state_q == ST_PROG2);
   assign state_o  = state_q;

   AST_HOLD_NO_ENTER: assert property (@(posedge clk) disable iff (rst)
      (!enter_i && !restore_i) |=> $stable(state_q)) else $error("state moved"); // R3

   AST_ERR_EXIT: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_ERR && enter_i) |=> (state_q == ST_IDLE)) else $error("error exit"); // R7

endmodule

// File: rtl/combo_lock.sv
module combo_lock
   import lock_pkg::*;
#(
   parameter int DIGIT_W    = 2,
   parameter int RST_FIRST  = 3,
   parameter int RST_SECOND = 1
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic [DIGIT_W-1:0]     code_i,
   input  logic                   enter_i,
   input  logic                   reset_combo_i,
   output logic                   open_o,
   output logic [2*DIGIT_W-1:0]   combo_o,
   output logic [STATUS_W-1:0]    status_o
);
   localparam longint DIGIT_VALUES = longint'(1) << DIGIT_W;

   generate
      if (DIGIT_W < 1 || DIGIT_W > 16) begin : g_bad_width
         $error("combo_lock: DIGIT_W must lie in 1..16");
      end
      if (RST_FIRST < 0 || longint'(RST_FIRST) >= DIGIT_VALUES) begin : g_bad_first
         $error("combo_lock: RST_FIRST does not fit in DIGIT_W bits");
      end
      if (RST_SECOND < 0 || longint'(RST_SECOND) >= DIGIT_VALUES) begin : g_bad_second
         $error("combo_lock: RST_SECOND does not fit in DIGIT_W bits");
      end
   endgenerate

   lock_state_t        state;
   logic               stage, commit;
   logic [DIGIT_W-1:0] first_d, second_d;

   lock_combo_store #(
      .DIGIT_W    (DIGIT_W),
      .RST_FIRST  (RST_FIRST),
      .RST_SECOND (RST_SECOND)
   ) store_i (
      .clk       (clk),
      .rst       (rst),
      .restore_i (reset_combo_i),
      .stage_i   (stage),
      .commit_i  (commit),
      .code_i    (code_i),
      .combo_o   (combo_o),
      .first_o   (first_d),
      .second_o  (second_d)
   );

   lock_fsm #(
      .DIGIT_W (DIGIT_W)
   ) fsm_i (
      .clk       (clk),
      .rst       (rst),
      .restore_i (reset_combo_i),
      .enter_i   (enter_i),
      .code_i    (code_i),
      .first_i   (first_d),
      .second_i  (second_d),
      .state_o   (state),
      .stage_o   (stage),
      .commit_o  (commit)
   );

   // Moore outputs: current state only
   assign open_o   = (state == ST_OPEN);
   assign status_o = status_of(state);

   AST_NO_EARLY_ERROR: assert property (@(posedge clk) disable iff (rst)
      (status_o == STAT_IDLE && enter_i && !reset_combo_i) |=> (status_o == STAT_WAIT2))
      else $error("early verdict"); // R5

   AST_OPEN_ENTRY: assert property (@(posedge clk) disable iff (rst)
      $rose(open_o) |-> ($past(status_o) == STAT_WAIT2 || $past(status_o) == STAT_PROG2))
      else $error("open from wrong state"); // R4

   AST_ERROR_ENTRY: assert property (@(posedge clk) disable iff (rst)
      $rose(status_o == STAT_ERROR) |-> ($past(status_o) == STAT_WAIT2))
      else $error("error from wrong state"); // R6

   AST_RESTORE_IDLE: assert property (@(posedge clk) disable iff (rst)
      reset_combo_i |=> (status_o == STAT_IDLE)) else $error("restore not idle"); // R2

   AST_PROG_LOCKED: assert property (@(posedge clk) disable iff (rst)
      (status_o == STAT_PROG1 || status_o == STAT_PROG2) |-> !open_o)
      else $error("open while programming"); // R8

endmodule

// File: tb/combo_lock_tb_top.sv
module combo_lock_tb_top;
   localparam int DW = 2;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [DW-1:0] code = '0;
   logic          enter = 1'b0;
   logic          rcombo = 1'b0;
   logic          open_w;
   logic [2*DW-1:0] combo_w;
   logic [2:0]    status_w;

   int n_chk  = 0;
   int n_fail = 0;
   int cycles = 0;

   always #2 clk = ~clk;

   combo_lock #(.DIGIT_W(DW), .RST_FIRST(3), .RST_SECOND(1)) dut_i (
      .clk           (clk),
      .rst           (rst),
      .code_i        (code),
      .enter_i       (enter),
      .reset_combo_i (rcombo),
      .open_o        (open_w),
      .combo_o       (combo_w),
      .status_o      (status_w)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 20000) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected fewer than 20000", cycles);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Drive at a falling edge; after the next falling edge the state has moved
   task automatic press(input logic [DW-1:0] c);
      @(negedge clk);
      code  = c;
      enter = 1'b1;
      @(negedge clk);
      enter = 1'b0;
   endtask

   task automatic restore_combo();
      @(negedge clk);
      rcombo = 1'b1;
      @(negedge clk);
      rcombo = 1'b0;
   endtask

   task automatic t_reset();
      rst = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1 status in reset", status_w, 0);
      chk("R1 open in reset", open_w, 0);
      rst = 1'b0;
      @(negedge clk);
      chk("R1 status after reset", status_w, 0);
      restore_combo();
      chk("R2 factory combination", combo_w, 4'b1101);
      chk("R2 idle after restore", status_w, 0);
   endtask

   task automatic t_hold();
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         code = k[DW-1:0];
      end
      chk("R3 idle hold status", status_w, 0);
      press(2'b11);
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         code = k[DW-1:0];
      end
      chk("R3 wait2 hold status", status_w, 1);
      chk("R3 combo hold", combo_w, 4'b1101);
      press(2'b01);
      chk("R4 status open", status_w, 2);
      chk("R4 open high", open_w, 1);
      repeat (5) @(negedge clk);
      chk("R3 open hold", open_w, 1);
      restore_combo();
   endtask

   task automatic t_sweep();
      for (int a = 0; a < 4; a++) begin
         for (int b = 0; b < 4; b++) begin
            press(a[DW-1:0]);
            chk("R5 no early error", status_w, 1);
            press(b[DW-1:0]);
            if (a == 3 && b == 1) begin
               chk("R4 sweep open", status_w, 2);
               chk("R4 sweep open pin", open_w, 1);
               restore_combo();
            end else begin
               chk(a == 3 ? "R6 sweep error" : "R5 sweep error", status_w, 5);
               chk("R5 sweep locked", open_w, 0);
               press(2'b00);
               chk("R7 error to idle", status_w, 0);
            end
         end
      end
   endtask

   task automatic t_program();
      press(2'b11);
      press(2'b01);
      chk("R4 open before prog", status_w, 2);
      press(2'b10);
      chk("R8 prog1 status", status_w, 3);
      chk("R8 locked in prog1", open_w, 0);
      press(2'b00);
      chk("R9 prog2 status", status_w, 4);
      chk("R9 combo unchanged", combo_w, 4'b1101);
      press(2'b10);
      chk("R10 back to open", status_w, 2);
      chk("R10 new combination", combo_w, 4'b0010);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk("R1 reset keeps combo", combo_w, 4'b0010);
      chk("R1 reset relocks", open_w, 0);
      press(2'b11);
      press(2'b01);
      chk("R10 old combo rejected", status_w, 5);
      press(2'b00);
      press(2'b00);
      press(2'b10);
      chk("R10 new combo opens", status_w, 2);
   endtask

   task automatic t_priority();
      press(2'b01);
      chk("R8 prog1 again", status_w, 3);
      press(2'b11);
      chk("R9 prog2 again", status_w, 4);
      @(negedge clk);
      code   = 2'b00;
      enter  = 1'b1;
      rcombo = 1'b1;
      @(negedge clk);
      enter  = 1'b0;
      rcombo = 1'b0;
      chk("R11 restore beats enter status", status_w, 0);
      chk("R11 restore beats enter combo", combo_w, 4'b1101);
      press(2'b11);
      @(negedge clk);
      rst    = 1'b1;
      rcombo = 1'b1;
      enter  = 1'b1;
      code   = 2'b01;
      @(negedge clk);
      rst    = 1'b0;
      rcombo = 1'b0;
      enter  = 1'b0;
      chk("R11 reset beats enter", status_w, 0);
      chk("R11 combo after reset and restore", combo_w, 4'b1101);
   endtask

   initial begin
      t_reset();
      t_hold();
      t_sweep();
      t_program();
      t_priority();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule